// File: doc/BRIEF.md
# Two-wire serial memory slave engine

This block is the bus-facing protocol engine of a 256-byte serial memory attached to a two-wire bus. It samples the clock and data lines with a fast system clock and detects start and stop conditions. It checks the device address byte against a fixed family code and three strap inputs. It accepts a word address and then data bytes. It answers every accepted byte by pulling the data line low on the ninth clock, and it shifts read data out MSB first. The data line output is a single pull-low enable. The bus side of the board resolves it as an open-drain line.

The block keeps an internal address pointer that survives from one transaction to the next. This pointer supports current-address reads, sequential reads and random reads, where a random read is an address-only write followed by a repeated start. Write data leaves the block as one-cycle byte strobes, each carrying an address and a data byte. A stop that follows at least one data byte raises a one-cycle commit pulse. The page buffer, the programming timer and the array sit outside the block. They report back only through a busy input. While busy is high, the block refuses device address bytes so that a master can poll for completion.

Top module: `twi_mem_slave`

## Requirements
- R1: A start (data falling while clock is high) at any bit position abandons the current transfer and begins reception of a new device address byte. A stop (data rising while clock is high) returns the block to idle.
- R2: The device address byte is acknowledged only when its upper nibble is 1010 and bits 3..1 equal `strap_i`. Bit 0 selects the direction: 1 is read, 0 is write. The acknowledge appears as `sda_pull_o` high during the ninth clock.
- R3: After a device address that does not match, the block gives no acknowledge and ignores all bus traffic until the next start. No write strobe and no commit result from that traffic.
- R4: While `busy_i` is high, no device address byte is acknowledged.
- R5: In a write, the word address byte and every data byte are acknowledged. Each data byte produces exactly one `wr_stb_o` pulse carrying the byte and its target address.
- R6: During a write, the low 4 bits of the pointer (the column) step by one after each data byte and wrap within the 16-byte page. Bits 7..4 (the row) stay fixed. The pointer left after the write is the rolled-over column in the same row.
- R7: A stop received after at least one data byte gives one `wr_commit_o` pulse. A stop directly after the word address, or a repeated start, gives none.
- R8: A read returns the byte at the pointer, MSB first, and advances the pointer by one. The pointer keeps its value between transactions.
- R9: A read continues with the next byte while the master acknowledges, and ends when the master does not acknowledge. The pointer wraps from 255 to 0.
- R10: The word address of a write loads the pointer. A read after a repeated start returns the byte at that address.
- R11: `sda_pull_o` is low after reset, rises only in the low phase of the clock line, and is released once the acknowledge clock or the master's not-acknowledge ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved) |
| strap_i | input | 3 | Chip-select strap value |
| busy_i | input | 1 | Programming in progress |
| sda_pull_o | output | 1 | Pull data line low when 1 |
| rd_addr_o | output | 8 | Array read address (the pointer) |
| rd_data_i | input | 8 | Array data at `rd_addr_o` |
| wr_stb_o | output | 1 | One-cycle byte-load strobe |
| wr_addr_o | output | 8 | Address of the loaded byte |
| wr_data_o | output | 8 | Loaded byte |
| wr_commit_o | output | 1 | One-cycle pulse starting programming |

## Verification
Two events can fall on the same clock-line falling edge. One is the acknowledge decision for a byte. The other is the action that byte causes: a device match can start the first read-bit drive, and a data byte is acknowledged on the same fall that loads the pointer or emits the strobe with its in-page increment. The bench provokes this with a random read that crosses the 255-to-0 boundary, and with a 20-byte page write that wraps the column. It judges the outcome from each returned byte, each strobe address and the pointer left behind, all computed arithmetically. A sweep of every strap value against every select code checks the address match.

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int AW = 8,
  parameter int PW = 4,
  parameter logic [3:0] FAMILY = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  input  logic          busy_i,
  output logic          sda_pull_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_commit_o
);

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_ADR, ST_WR, ST_RD} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_q, sda_q;
  st_t           st;
  logic [3:0]    bit_cnt;
  logic [7:0]    sh;
  logic [6:0]    tx;
  logic          rw_q, mack_q, wr_seen, pull_q;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  wire scl_now   = scl_sy[1];
  wire sda_now   = sda_sy[1];
  wire scl_rise  = scl_now & ~scl_q;
  wire scl_fall  = ~scl_now & scl_q;
  wire bus_start = scl_now & scl_q & sda_q & ~sda_now;
  wire bus_stop  = scl_now & scl_q & ~sda_q & sda_now;
  wire dev_hit   = (sh[7:4] == FAMILY) && (sh[3:1] == strap_i) && !busy_i;
  wire [AW-1:0] ptr_col_next = {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};

  assign sda_pull_o = pull_q;
  assign rd_addr_o  = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st          <= ST_IDLE;
      bit_cnt     <= '0;
      sh          <= '0;
      tx          <= '0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      wr_seen     <= 1'b0;
      pull_q      <= 1'b0;
      ptr         <= '0;
      wr_stb_o    <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      wr_stb_o    <= 1'b0;
      wr_commit_o <= 1'b0;
      if (bus_start) begin
        st      <= ST_DEV;
        bit_cnt <= '0;
        pull_q  <= 1'b0;
        wr_seen <= 1'b0;
      end else if (bus_stop) begin
        if (st == ST_WR && wr_seen) wr_commit_o <= 1'b1;
        st      <= ST_IDLE;
        pull_q  <= 1'b0;
        wr_seen <= 1'b0;
      end else if (st == ST_RD) begin
        if (scl_rise) begin
          bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt == 4'd8) mack_q <= ~sda_now;
        end else if (scl_fall) begin
          if (bit_cnt == 4'd8) pull_q <= 1'b0;
          else if (bit_cnt == 4'd9) begin
            if (mack_q) begin
              tx      <= rd_data_i[6:0];
              pull_q  <= ~rd_data_i[7];
              ptr     <= ptr + 1'b1;
              bit_cnt <= '0;
            end else begin
              st     <= ST_IDLE;
              pull_q <= 1'b0;
            end
          end else if (bit_cnt != 4'd0) begin
            tx     <= {tx[5:0], 1'b0};
            pull_q <= ~tx[6];
          end
        end
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt < 4'd8) sh <= {sh[6:0], sda_now};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall) begin
          if (bit_cnt == 4'd8) begin
            case (st)
              ST_DEV: if (dev_hit) begin
                pull_q <= 1'b1;
                rw_q   <= sh[0];
              end else st <= ST_IDLE;
              ST_ADR: begin
                pull_q <= 1'b1;
                ptr    <= sh[AW-1:0];
              end
              ST_WR: begin
                pull_q    <= 1'b1;
                wr_stb_o  <= 1'b1;
                wr_addr_o <= ptr;
                wr_data_o <= sh;
                ptr       <= ptr_col_next;
                wr_seen   <= 1'b1;
              end
              default: ;
            endcase
          end else if (bit_cnt == 4'd9) begin
            pull_q  <= 1'b0;
            bit_cnt <= '0;
            case (st)
              ST_DEV: if (rw_q) begin
                st     <= ST_RD;
                tx     <= rd_data_i[6:0];
                pull_q <= ~rd_data_i[7];
                ptr    <= ptr + 1'b1;
              end else st <= ST_ADR;
              ST_ADR: st <= ST_WR;
              default: ;
            endcase
          end
        end
      end
    end

  // R4
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEV && scl_fall && bit_cnt == 4'd8 && busy_i) |=> !sda_pull_o);

  // R11
  pull_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !$past(scl_now));

  // R5
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  // R7
  commit_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> ($past(st) == ST_WR && !wr_stb_o));

  // R6
  row_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o && $past(wr_stb_o, 2) == 1'b0 && st == ST_WR) |-> (ptr[AW-1:PW] == wr_addr_o[AW-1:PW]));

endmodule

// File: tb/twi_mem_slave_tb_top.sv
module twi_mem_slave_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic [2:0] strap = 3'd0;
  logic       sda_pull, wr_stb, wr_commit;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  wire        sda_bus = sda_m & ~sda_pull;

  logic [7:0] mem [256];
  assign rd_data = mem[rd_addr];

  twi_mem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
    .busy_i(busy), .sda_pull_o(sda_pull), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit)
  );

  int checks = 0, fails = 0, n_stb = 0, n_commit = 0;
  logic [7:0] stb_addr [64];
  logic [7:0] stb_data [64];

  always @(negedge clk) if (rst_n) begin
    if (wr_stb) begin
      if (n_stb < 64) begin
        stb_addr[n_stb] = wr_addr;
        stb_data[n_stb] = wr_data;
      end
      mem[wr_addr] = wr_data;
      n_stb++;
    end
    if (wr_commit) n_commit++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sda_m = b; w(5); scl = 1'b1; w(5); r = sda_bus; w(5); scl = 1'b0; w(5);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(5); scl = 1'b1; w(5); sda_m = 1'b0; w(5); scl = 1'b0; w(5);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(5); scl = 1'b1; w(5); sda_m = 1'b1; w(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, r);
      d[i] = r;
    end
    bit_x(~mack, r);
  endtask

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int s0, c0;
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    w(4);
    rst_n = 1'b1;
    w(4);
    chk("R11 reset pull", sda_pull, 0);
    chk("R5 reset strobe", wr_stb, 0);

    // R2 / R3: all straps against all select codes
    for (int s = 0; s < 8; s++)
      for (int sel = 0; sel < 8; sel++) begin
        strap = 3'(s);
        bus_start();
        send_byte({4'b1010, 3'(sel), 1'b0}, ack);
        chk($sformatf("R2 match strap=%0d sel=%0d", s, sel), ack, (s == sel) ? 1 : 0);
        bus_stop();
      end

    strap = 3'd5;
    s0 = n_stb; c0 = n_commit;
    bus_start();
    send_byte({4'b1011, 3'd5, 1'b0}, ack);
    chk("R2 wrong family", ack, 0);
    send_byte(8'h20, ack);
    chk("R3 ignored byte ack", ack, 0);
    send_byte(8'h77, ack);
    bus_stop();
    chk("R3 no strobe after mismatch", n_stb - s0, 0);
    chk("R3 no commit after mismatch", n_commit - c0, 0);

    busy = 1'b1;
    bus_start();
    send_byte({4'b1010, 3'd5, 1'b0}, ack);
    chk("R4 busy nack", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte({4'b1010, 3'd5, 1'b0}, ack);
    chk("R4 ack after busy", ack, 1);
    bus_stop();

    // R5 / R7: three-byte write
    s0 = n_stb; c0 = n_commit;
    bus_start();
    send_byte({4'b1010, 3'd5, 1'b0}, ack);
    send_byte(8'h23, ack);
    chk("R5 word address ack", ack, 1);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'(8'h3C + 7 * k), ack);
      chk("R5 data ack", ack, 1);
    end
    bus_stop();
    w(4);
    chk("R5 strobe count", n_stb - s0, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R5 strobe addr", stb_addr[s0 + k], 8'h23 + k);
      chk("R5 strobe data", stb_data[s0 + k], 8'(8'h3C + 7 * k));
    end
    chk("R7 commit after write", n_commit - c0, 1);

    // R6: page roll over 20 bytes
    s0 = n_stb; c0 = n_commit;
    bus_start();
    send_byte({4'b1010, 3'd5, 1'b0}, ack);
    send_byte(8'h4C, ack);
    for (int k = 0; k < 20; k++) send_byte(8'(8'hA0 + k), ack);
    bus_stop();
    w(4);
    for (int k = 0; k < 20; k++)
      chk($sformatf("R6 roll addr k=%0d", k), stb_addr[s0 + k], 8'h40 + ((12 + k) % 16));
    chk("R7 commit after page", n_commit - c0, 1);
    bus_start();
    send_byte({4'b1010, 3'd5, 1'b1}, ack);
    chk("R8 read ack", ack, 1);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R6 pointer after roll", d, 8'hA4);

    // R7 / R10: address-only write loads pointer
    s0 = n_stb; c0 = n_commit;
    bus_start();
    send_byte({4'b1010, 3'd5, 1'b0}, ack);
    send_byte(8'h90, ack);
    bus_stop();
    w(4);
    chk("R7 no commit address only", n_commit - c0, 0);
    chk("R7 no strobe address only", n_stb - s0, 0);
    bus_start();
    send_byte({4'b1010, 3'd5, 1'b1}, ack);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R10 read at loaded address", d, init_val(8'h90));
    bus_start();
    send_byte({4'b1010, 3'd5, 1'b1}, ack);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R8 pointer kept across reads", d, init_val(8'h91));
    chk("R11 released after nack", sda_pull, 0);

    // R9 / R10: random read with restart, sequential across wrap
    c0 = n_commit;
    bus_start();
    send_byte({4'b1010, 3'd5, 1'b0}, ack);
    send_byte(8'hFD, ack);
    bus_start();
    send_byte({4'b1010, 3'd5, 1'b1}, ack);
    chk("R10 read after restart ack", ack, 1);
    for (int k = 0; k < 5; k++) begin
      recv_byte(k != 4, d);
      chk($sformatf("R9 sequential k=%0d", k), d, init_val((8'hFD + k) % 256));
    end
    bus_stop();
    w(4);
    chk("R7 no commit on restart", n_commit - c0, 0);
    chk("R11 released after read", sda_pull, 0);

    // R1: start in the middle of a byte
    bus_start();
    bit_x(1'b1, ack); bit_x(1'b0, ack); bit_x(1'b1, ack);
    bus_start();
    send_byte({4'b1010, 3'd5, 1'b0}, ack);
    chk("R1 restart mid byte ack", ack, 1);
    send_byte(8'h10, ack);
    bus_stop();
    bus_start();
    send_byte({4'b1010, 3'd5, 1'b1}, ack);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R1 restart loaded pointer", d, init_val(8'h10));

    w(10);
    finish_run();
  end
endmodule